// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block merges eight sub-interrupt request lines into a single host interrupt. Each line owns one bit of an 8-bit status register. The bit copies the line's level every time the line changes. Between changes, the host may overwrite the whole register. A mask register gates the status bits, and the host interrupt is the OR of the surviving bits.

A byte-wide register port gives the host access to the block:
- The status, mask and routing registers can be read and written.
- A fixed revision identifier can be read.
- The routing register is plain storage and has no effect on the output.

Source slots are assigned as follows: 0 NAND flash controller, 1 memory card, 2 USB host, 3 serial port, 4 framebuffer. Slots 5 to 7 are spare inputs.

Top module: `irq_aggregator`

## Requirements
- R1: After the active-low asynchronous reset, the status, mask and routing registers all read 0x00 and `irq_o` is low. While the mask is zero, `irq_o` stays low.
- R2: When a source line differs from its value on the previous clock edge and is now 1, the matching status bit is 1 after that edge.
- R3: When a source line differs from its value on the previous clock edge and is now 0, the matching status bit is 0 after that edge.
- R4: `irq_o` is the OR of (status AND mask). It reflects the register values set at the most recent clock edge, with no further delay.
- R5: A write to offset 0x50 replaces every status bit whose source did not change in that cycle with the written bit.
- R6: When a source change and a host status write fall in the same cycle, the changed bit takes the line level and the write is lost for that bit.
- R7: The mask at offset 0x52 and the routing register at offset 0x54 read back what was written. The routing value never affects `irq_o`.
- R8: Reading offset 0x08 returns 0x03 and reading offset 0x09 returns 0x00. Writes to these offsets change nothing.
- R9: Reads of any offset other than 0x08, 0x09, 0x50, 0x52 and 0x54 return 0x00. Writes to such offsets change no register and do not change `irq_o`.
- R10: A status bit whose line holds steady keeps its value until the host writes it. A line held high does not set its bit again after the host clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 8 | Sub-interrupt request levels, one per slot |
| reg_addr_i | input | 8 | Register byte offset |
| reg_we_i | input | 1 | Write strobe, taken at the rising clock edge |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational from the current register state |
| irq_o | output | 1 | Host interrupt request |

## Verification
Every register, and therefore every result, updates on the first rising edge after its stimulus is presented:
- source changes, status writes and mask writes reach `irq_o` after that one edge;
- the read data of the same offset shows the new value after that same edge.

The bench presents each stimulus at a falling edge and waits for one rising edge. It then samples a quarter period later, so every check lands one register stage after its cause. Same-cycle collisions between a line change and a status write are placed inside a single vector, so that both reach the same edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int NUM_SRC = 8;

  localparam logic [ADDR_W-1:0] OFS_REV_LO = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_REV_HI = 8'h09;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h52;
  localparam logic [ADDR_W-1:0] OFS_ROUTE  = 8'h54;

  localparam logic [DATA_W-1:0] REV_ID = 8'h03;

  // source slot assignment
  typedef enum logic [2:0] {
    SRC_NAND  = 3'd0,
    SRC_CARD  = 3'd1,
    SRC_USBH  = 3'd2,
    SRC_UART  = 3'd3,
    SRC_FB    = 3'd4,
    SRC_SPARE = 3'd5
  } src_slot_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_REV_LO,
    SEL_REV_HI,
    SEL_STATUS,
    SEL_MASK,
    SEL_ROUTE
  } reg_sel_e;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_agg_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o
);

  always_comb begin
    unique case (addr_i)
      AW'(OFS_REV_LO): sel_o = SEL_REV_LO;
      AW'(OFS_REV_HI): sel_o = SEL_REV_HI;
      AW'(OFS_STATUS): sel_o = SEL_STATUS;
      AW'(OFS_MASK):   sel_o = SEL_MASK;
      AW'(OFS_ROUTE):  sel_o = SEL_ROUTE;
      default:         sel_o = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/irq_status_track.sv
module irq_status_track #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o
);

  logic [N-1:0] src_q;
  logic [N-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  // a line change overrides a host write on the same bit
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  status_q[i] <= 1'b0;
      else if (src_i[i] != src_q[i]) status_q[i] <= src_i[i];
      else if (wr_i)                status_q[i] <= wdata_i[i];
    end
  end

  assign status_o = status_q;

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_agg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int N  = NUM_SRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  reg_sel_e      sel_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  status_i,
  output logic [N-1:0]  mask_o,
  output logic [DW-1:0] rdata_o
);

  logic [N-1:0]  mask_q;
  logic [DW-1:0] route_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      route_q <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_MASK)  mask_q  <= wdata_i[N-1:0];
      if (sel_i == SEL_ROUTE) route_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_REV_LO: rdata_o = DW'(REV_ID);
      SEL_STATUS: rdata_o = DW'(status_i);
      SEL_MASK:   rdata_o = DW'(mask_q);
      SEL_ROUTE:  rdata_o = route_q;
      default:    rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_we_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);

  reg_sel_e        sel;
  logic [NSRC-1:0] status;
  logic [NSRC-1:0] mask;
  logic            wr_status;

  irq_addr_decode #(.AW(AW)) u_dec (
    .addr_i (reg_addr_i),
    .sel_o  (sel)
  );

  assign wr_status = reg_we_i && (sel == SEL_STATUS);

  irq_status_track #(.N(NSRC)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .wr_i     (wr_status),
    .wdata_i  (reg_wdata_i[NSRC-1:0]),
    .status_o (status)
  );

  irq_ctrl_regs #(.DW(DW), .N(NSRC)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status),
    .mask_o   (mask),
    .rdata_o  (reg_rdata_o)
  );

  assign irq_o = |(status & mask);

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] src_i,
  input logic [AW-1:0]   reg_addr_i,
  input logic            reg_we_i,
  input logic [DW-1:0]   reg_wdata_i,
  input logic [DW-1:0]   reg_rdata_o,
  input logic            irq_o,
  input logic [NSRC-1:0] status,
  input logic [NSRC-1:0] mask
);

  logic [NSRC-1:0] prev_src;
  logic [NSRC-1:0] chg;
  logic            wr_st;
  logic            mapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_src <= '0;
    else         prev_src <= src_i;
  end

  assign chg    = src_i ^ prev_src;
  assign wr_st  = reg_we_i && (reg_addr_i == AW'(OFS_STATUS));
  assign mapped = (reg_addr_i == AW'(OFS_REV_LO)) || (reg_addr_i == AW'(OFS_REV_HI)) ||
                  (reg_addr_i == AW'(OFS_STATUS)) || (reg_addr_i == AW'(OFS_MASK)) ||
                  (reg_addr_i == AW'(OFS_ROUTE));

  a_r1_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);

  // R2 and R3: changed bits take the line level
  a_r2_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg != '0) |=> ((status & $past(chg)) == ($past(src_i) & $past(chg))));

  a_r5_write_replace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st && chg == '0) |=> (status == $past(reg_wdata_i[NSRC-1:0])));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_st && chg == '0) |=> $stable(status));

  a_r8_rev_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == AW'(OFS_REV_LO)) |-> (reg_rdata_o == DW'(REV_ID)));

  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (reg_rdata_o == '0));

endmodule

bind irq_aggregator irq_aggregator_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_i       (src_i),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .status      (status),
  .mask        (mask)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] src_i = '0;
  logic [7:0] reg_addr_i = '0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       irq_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_aggregator dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .reg_addr_i  (reg_addr_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
  );

  // {src, we, addr, wdata, exp_rdata, exp_irq, req}
  localparam logic [41:0] VEC [NVEC] = '{
    {8'h00, 1'b0, 8'h50, 8'h00, 8'h00, 1'b0, 8'd1},  // R1 idle
    {8'h00, 1'b1, 8'h52, 8'hFF, 8'hFF, 1'b0, 8'd7},  // R7 mask all
    {8'h01, 1'b0, 8'h50, 8'h00, 8'h01, 1'b1, 8'd2},  // R2 NAND rises
    {8'h05, 1'b0, 8'h50, 8'h00, 8'h05, 1'b1, 8'd2},  // R2 USB host rises
    {8'h04, 1'b0, 8'h50, 8'h00, 8'h04, 1'b1, 8'd3},  // R3 NAND falls
    {8'h04, 1'b1, 8'h52, 8'h01, 8'h01, 1'b0, 8'd4},  // R4 masked off
    {8'h04, 1'b1, 8'h52, 8'h04, 8'h04, 1'b1, 8'd4},  // R4 unmasked
    {8'h04, 1'b1, 8'h50, 8'h00, 8'h00, 1'b0, 8'd5},  // R5 clear while held
    {8'h04, 1'b0, 8'h50, 8'h00, 8'h00, 1'b0, 8'd10}, // R10 held line no reset
    {8'h04, 1'b1, 8'h50, 8'hA0, 8'hA0, 1'b0, 8'd5},  // R5 arbitrary byte
    {8'h00, 1'b1, 8'h50, 8'h04, 8'h00, 1'b0, 8'd6},  // R6 fall beats write
    {8'h10, 1'b1, 8'h50, 8'h00, 8'h10, 1'b0, 8'd6},  // R6 rise beats write
    {8'h10, 1'b1, 8'h54, 8'h5A, 8'h5A, 1'b0, 8'd7},  // R7 route storage
    {8'h10, 1'b1, 8'h52, 8'h10, 8'h10, 1'b1, 8'd4},  // R4 framebuffer
    {8'h10, 1'b1, 8'h54, 8'h00, 8'h00, 1'b1, 8'd7},  // R7 route no effect
    {8'h10, 1'b0, 8'h08, 8'h00, 8'h03, 1'b1, 8'd8},  // R8 rev low
    {8'h10, 1'b0, 8'h09, 8'h00, 8'h00, 1'b1, 8'd8},  // R8 rev high
    {8'h10, 1'b1, 8'h53, 8'hFF, 8'h00, 1'b1, 8'd9},  // R9 unmapped write
    {8'h10, 1'b0, 8'h52, 8'h00, 8'h10, 1'b1, 8'd9},  // R9 mask intact
    {8'h10, 1'b0, 8'h50, 8'h00, 8'h10, 1'b1, 8'd9},  // R9 status intact
    {8'h10, 1'b1, 8'h08, 8'hFF, 8'h03, 1'b1, 8'd8}   // R8 rev write ignored
  };

  task automatic check(input int req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] s, input logic we, input logic [7:0] a,
                      input logic [7:0] d);
    @(negedge clk_i);
    src_i = s; reg_we_i = we; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    #(CLK_PERIOD/4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #(CLK_PERIOD/4);
    // R1 reset state
    check(1, "irq in reset", int'(irq_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][41:34], VEC[i][33], VEC[i][32:25], VEC[i][24:17]);
      check(int'(VEC[i][7:0]), $sformatf("vec %0d rdata", i), int'(reg_rdata_o),
            int'(VEC[i][16:9]));
      check(int'(VEC[i][7:0]), $sformatf("vec %0d irq", i), int'(irq_o),
            int'(VEC[i][8]));
    end

    // R1 mid-run reset with a line held high
    @(negedge clk_i);
    reg_we_i = 1'b0;
    src_i = 8'h80;
    rst_ni = 1'b0;
    #1;
    check(1, "irq after reset", int'(irq_o), 0);
    reg_addr_i = 8'h50; #1;
    check(1, "status after reset", int'(reg_rdata_o), 0);
    reg_addr_i = 8'h52; #1;
    check(1, "mask after reset", int'(reg_rdata_o), 0);
    reg_addr_i = 8'h54; #1;
    check(1, "route after reset", int'(reg_rdata_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 line high through reset release sets its bit on the first edge
    step(8'h80, 1'b0, 8'h50, 8'h00);
    check(2, "spare bit after release", int'(reg_rdata_o), 8'h80);
    check(1, "irq with mask zero", int'(irq_o), 0);
    step(8'h80, 1'b1, 8'h52, 8'h80);
    check(4, "irq after mask write", int'(irq_o), 1);
    step(8'h00, 1'b0, 8'h50, 8'h00);
    check(3, "irq after spare falls", int'(irq_o), 0);

    finish_run();
  end

endmodule